// File: doc/BRIEF.md
# BISYNC Transmit Sync Inserter

This block produces the character stream for a byte-oriented synchronous transmitter. When the block is enabled, it starts with a run of sync pairs. The pairs are written as SYN1 followed by SYN2, and both codes come from configuration inputs. After at least the programmed number of pairs, the block passes message bytes from a ready/valid source. At the end of each message it sends the block check value, which an external unit supplies. It then sends another run of sync pairs before the next message. While no message is waiting, the pairs continue, so the line always carries whole pairs.

A 4-bit count sets the minimum number of pairs to count+1. Software may rewrite the count while the block is running. The block latches the value at the start of each sync run, so a new value takes effect from the next run.

In sum-check mode without transparency, the top data bit is replaced by parity and the check field is one byte. Otherwise the check field is two bytes. A bit-reversal option sends every character msb first. The request-to-send output stays high while the block is active. The serializer pulls one character per cycle in which `txReady` is high.

Top module: `bisync_sync_inserter`

## Requirements
- R1: While `rstN` is low, `rts`, `txValid` and `msgReady` are all low.
- R2: Let N be the value of `pairCount` when `enable` is first seen high. If a message is already waiting at that point, exactly N+1 sync pairs come before its first data character. If the message arrives later, at least N+1 pairs come before it.
- R3: Let N be the value of `pairCount` when the last check byte of a message is taken. Exactly N+1 sync pairs separate that check byte from the first data character of the next waiting message. The count input may change at any time.
- R4: Sync characters always appear as whole pairs, first `syn1Code` and then `syn2Code`. Pairs keep coming while no message is waiting, and a message starts only after a SYN2.
- R5: `msgReady` is high only during the data phase and only while `txReady` is high. Data characters leave in the order they were accepted. When parity is off, each data character is sent unchanged.
- R6: When `sumCheck`=1 and `transparent`=0, bit 7 of each data character is replaced by the XOR of bits 6:0, which gives even parity over the eight bits.
- R7: Check bytes follow the last data character and are never inverted. Normally two are sent: `chkValue[7:0]` first, then `chkValue[15:8]`. When `sumCheck`=1 and `transparent`=0, only `chkValue[7:0]` is sent.
- R8: When `msbFirst`=1, every character is sent bit-reversed: output bit i equals bit 7-i of the character. This covers sync characters, data characters after parity, and check bytes.
- R9: `rts` rises after `enable` is seen high. It falls only when a sync pair completes while `enable` is low. A message in progress is finished first, together with its check bytes. `txValid` is high only while `rts` is high.
- R10: While the source holds its data, a character offered with `txReady` low is still offered unchanged in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Transmitter enable |
| pairCount | input | 4 | Minimum sync pairs minus one |
| syn1Code | input | 8 | First character of a sync pair |
| syn2Code | input | 8 | Second character of a sync pair |
| sumCheck | input | 1 | 1: sum-check mode (parity, one check byte) |
| transparent | input | 1 | 1: transparent mode (no parity, two check bytes) |
| msbFirst | input | 1 | 1: bit-reverse every character |
| msgData | input | 8 | Message byte |
| msgValid | input | 1 | Message byte available |
| msgLast | input | 1 | Current byte ends the message |
| msgReady | output | 1 | Message byte taken this cycle |
| chkValue | input | 16 | Block check value from external arithmetic |
| txByte | output | 8 | Character to the serializer |
| txValid | output | 1 | Character offered |
| txReady | input | 1 | Serializer takes the character this cycle |
| rts | output | 1 | Request to send, high while active |

## Verification
The hardest situation to reach is a change of the pair count exactly between two messages. The new count must apply to the gap sync run, not to the run already in progress. To reach it, the bench rewrites `pairCount` in the same cycle the last message byte is accepted, while the check bytes are still pending. It also delays the first message so that extra idle pairs build up, and it stalls `txReady` in several periodic patterns. The bench locates the first data character by the accepted handshake and then checks that all earlier characters form whole SYN1/SYN2 pairs.

// File: rtl/bisync_tx_pkg.sv
package bisync_tx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SYNC,
    ST_DATA,
    ST_CHECK,
    ST_GAP
  } txState_t;

  localparam int CHK_IDX_W = 4;

  // strobes from control to datapath
  typedef struct packed {
    logic                 selData;
    logic                 selChk;
    logic                 synSecond;
    logic [CHK_IDX_W-1:0] chkIdx;
  } txStrobe_t;

endpackage

// File: rtl/bisync_tx_ctrl.sv
module bisync_tx_ctrl
  import bisync_tx_pkg::*;
#(
  parameter int PAIR_W    = 4,
  parameter int CHK_BYTES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic [PAIR_W-1:0] pairCount,
  input  logic              shortCheck,
  input  logic              msgValid,
  input  logic              msgLast,
  input  logic              txReady,
  output logic              txValid,
  output logic              msgReady,
  output logic              rts,
  output txStrobe_t         strobe
);

  localparam logic [CHK_IDX_W-1:0] FULL_LAST = CHK_IDX_W'(CHK_BYTES - 1);

  txState_t              state;
  logic [PAIR_W-1:0]     pairIdx;
  logic [PAIR_W-1:0]     target;
  logic                  secondHalf;
  logic [CHK_IDX_W-1:0]  chkIdx;

  logic                  inSync;
  logic                  countMet;
  logic [CHK_IDX_W-1:0]  lastIdx;

  assign inSync   = (state == ST_SYNC) || (state == ST_GAP);
  assign countMet = (pairIdx == target);
  assign lastIdx  = shortCheck ? '0 : FULL_LAST;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      pairIdx    <= '0;
      target     <= '0;
      secondHalf <= 1'b0;
      chkIdx     <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (enable) begin
            state      <= ST_SYNC;
            pairIdx    <= '0;
            secondHalf <= 1'b0;
            target     <= pairCount;
          end
        end
        ST_SYNC, ST_GAP: begin
          if (txReady) begin
            if (!secondHalf) begin
              secondHalf <= 1'b1;
            end else begin
              secondHalf <= 1'b0;
              if (!enable) begin
                state <= ST_IDLE;
              end else if (!countMet) begin
                pairIdx <= pairIdx + 1'b1;
              end else if (msgValid) begin
                state <= ST_DATA;
              end
            end
          end
        end
        ST_DATA: begin
          if (msgValid && txReady && msgLast) begin
            state  <= ST_CHECK;
            chkIdx <= '0;
          end
        end
        ST_CHECK: begin
          if (txReady) begin
            if (chkIdx == lastIdx) begin
              state      <= ST_GAP;
              pairIdx    <= '0;
              secondHalf <= 1'b0;
              target     <= pairCount;
            end else begin
              chkIdx <= chkIdx + 1'b1;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    rts              = (state != ST_IDLE);
    txValid          = inSync || (state == ST_CHECK) || ((state == ST_DATA) && msgValid);
    msgReady         = (state == ST_DATA) && txReady;
    strobe.selData   = (state == ST_DATA);
    strobe.selChk    = (state == ST_CHECK);
    strobe.synSecond = secondHalf;
    strobe.chkIdx    = chkIdx;
  end

endmodule

// File: rtl/bisync_tx_dp.sv
module bisync_tx_dp
  import bisync_tx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CHK_W  = 16
) (
  input  txStrobe_t         strobe,
  input  logic [DATA_W-1:0] syn1Code,
  input  logic [DATA_W-1:0] syn2Code,
  input  logic [DATA_W-1:0] msgData,
  input  logic [CHK_W-1:0]  chkValue,
  input  logic              parityOn,
  input  logic              msbFirst,
  output logic [DATA_W-1:0] txByte
);

  localparam int CHK_BYTES = CHK_W / DATA_W;

  logic [DATA_W-1:0] dataChar;
  logic [DATA_W-1:0] chkByte;
  logic [DATA_W-1:0] rawChar;
  logic [DATA_W-1:0] revChar;

  // parity replaces the top bit of a 7-bit character
  always_comb begin
    if (parityOn) dataChar = {^msgData[DATA_W-2:0], msgData[DATA_W-2:0]};
    else          dataChar = msgData;
  end

  always_comb begin
    chkByte = '0;
    for (int i = 0; i < CHK_BYTES; i++) begin
      if (strobe.chkIdx == CHK_IDX_W'(i)) chkByte = chkValue[i*DATA_W +: DATA_W];
    end
  end

  always_comb begin
    if (strobe.selData)        rawChar = dataChar;
    else if (strobe.selChk)    rawChar = chkByte;
    else if (strobe.synSecond) rawChar = syn2Code;
    else                       rawChar = syn1Code;
  end

  for (genvar g = 0; g < DATA_W; g++) begin : g_rev
    assign revChar[g] = rawChar[DATA_W-1-g];
  end

  assign txByte = msbFirst ? revChar : rawChar;

endmodule

// File: rtl/bisync_sync_inserter.sv
module bisync_sync_inserter
  import bisync_tx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CHK_W  = 16,
  parameter int PAIR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic [PAIR_W-1:0] pairCount,
  input  logic [DATA_W-1:0] syn1Code,
  input  logic [DATA_W-1:0] syn2Code,
  input  logic              sumCheck,
  input  logic              transparent,
  input  logic              msbFirst,
  input  logic [DATA_W-1:0] msgData,
  input  logic              msgValid,
  input  logic              msgLast,
  output logic              msgReady,
  input  logic [CHK_W-1:0]  chkValue,
  output logic [DATA_W-1:0] txByte,
  output logic              txValid,
  input  logic              txReady,
  output logic              rts
);

  localparam int CHK_BYTES = CHK_W / DATA_W;

  txStrobe_t strobe;
  logic      parityOn;

  assign parityOn = sumCheck & ~transparent;

  bisync_tx_ctrl #(
    .PAIR_W   (PAIR_W),
    .CHK_BYTES(CHK_BYTES)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .enable    (enable),
    .pairCount (pairCount),
    .shortCheck(parityOn),
    .msgValid  (msgValid),
    .msgLast   (msgLast),
    .txReady   (txReady),
    .txValid   (txValid),
    .msgReady  (msgReady),
    .rts       (rts),
    .strobe    (strobe)
  );

  bisync_tx_dp #(
    .DATA_W(DATA_W),
    .CHK_W (CHK_W)
  ) u_dp (
    .strobe  (strobe),
    .syn1Code(syn1Code),
    .syn2Code(syn2Code),
    .msgData (msgData),
    .chkValue(chkValue),
    .parityOn(parityOn),
    .msbFirst(msbFirst),
    .txByte  (txByte)
  );

endmodule

// File: rtl/bisync_sync_inserter_chk.sv
module bisync_sync_inserter_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              txValid,
  input logic              txReady,
  input logic [DATA_W-1:0] txByte,
  input logic              msgReady,
  input logic              rts
);

  always @(negedge clk) begin
    if (!rstN) begin
      assert_reset_quiet_R1: assert (!rts && !txValid && !msgReady)
        else $error("outputs active during reset");
    end
  end

  assert_accept_gated_R5: assert property (@(posedge clk) disable iff (!rstN)
    msgReady |-> (txReady && rts));

  assert_valid_needs_rts_R9: assert property (@(posedge clk) disable iff (!rstN)
    txValid |-> rts);

  assert_stop_after_transfer_R9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rts) |-> $past(txValid && txReady));

  assert_offer_held_R10: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && !txReady) |=> (txValid && $stable(txByte)));

endmodule

bind bisync_sync_inserter bisync_sync_inserter_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/test_bisync_sync_inserter.sv
module test_bisync_sync_inserter;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       enable = 1'b0;
  logic [3:0] pairCount = '0;
  logic [7:0] syn1Code = 8'h16;
  logic [7:0] syn2Code = 8'h32;
  logic       sumCheck = 1'b0;
  logic       transparent = 1'b0;
  logic       msbFirst = 1'b0;
  logic [7:0] msgData = '0;
  logic       msgValid = 1'b0;
  logic       msgLast = 1'b0;
  logic       msgReady;
  logic [15:0] chkValue = '0;
  logic [7:0] txByte;
  logic       txValid;
  logic       txReady = 1'b0;
  logic       rts;

  always #2 clk = ~clk;

  bisync_sync_inserter i_bisync_sync_inserter (
    .clk(clk), .rstN(rstN), .enable(enable), .pairCount(pairCount),
    .syn1Code(syn1Code), .syn2Code(syn2Code), .sumCheck(sumCheck),
    .transparent(transparent), .msbFirst(msbFirst), .msgData(msgData),
    .msgValid(msgValid), .msgLast(msgLast), .msgReady(msgReady),
    .chkValue(chkValue), .txByte(txByte), .txValid(txValid),
    .txReady(txReady), .rts(rts)
  );

  int vectors = 0;
  int fails = 0;
  int cycTotal = 0;

  logic [7:0] rec [0:1023];
  bit         recData [0:1023];
  int         recN;
  logic [7:0] expB [0:1023];
  string      expTag [0:1023];
  int         expN;

  always @(posedge clk) begin
    cycTotal++;
    if (cycTotal > 190000) begin
      fails++;
      $display("FAIL watchdog: run did not complete (actual %0d cycles, expected < 190000)", cycTotal);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, expv);
    end
  endtask

  function automatic logic [7:0] rev8(input logic [7:0] b);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = b[7-i];
    return r;
  endfunction

  function automatic logic [7:0] dataOf(input int n, input int msg, input int i);
    return 8'(n * 29 + msg * 101 + i * 53 + 7);
  endfunction

  function automatic logic [7:0] wire8(input logic [7:0] c, input bit msb);
    return msb ? rev8(c) : c;
  endfunction

  task automatic pushExp(input logic [7:0] b, input string tag);
    expB[expN] = b;
    expTag[expN] = tag;
    expN++;
  endtask

  task automatic runCase(input int n, input int n1, input int n2, input bit sc,
                         input bit tr, input bit msb, input int delay,
                         input int readyMode, input int len0, input int len1);
    int cyc;
    int msgIdx;
    int byteIdx;
    int k;
    int t;
    int lens [2];
    bit par;
    bit prevHold;
    logic [7:0] prevByte;
    logic [7:0] c;
    logic [7:0] s1w;
    logic [7:0] s2w;
    string dtag;
    string ctag;

    lens[0] = len0;
    lens[1] = len1;
    par = sc && !tr;

    @(negedge clk);
    rstN = 1'b0; enable = 1'b0; msgValid = 1'b0; txReady = 1'b0; msgLast = 1'b0;
    pairCount = 4'(n1);
    syn1Code = 8'(8'h16 + n);
    syn2Code = 8'(8'h32 ^ (n << 2));
    sumCheck = sc; transparent = tr; msbFirst = msb;
    chkValue = 16'hC3A5 ^ 16'((n << 8) | (n1 * 3 + int'(sc) + 2 * int'(tr)));
    #1;
    // R1: reset state
    check(!rts, "R1 rts in reset", rts, 0);
    check(!txValid, "R1 txValid in reset", txValid, 0);
    check(!msgReady, "R1 msgReady in reset", msgReady, 0);
    @(negedge clk);
    rstN = 1'b1;
    enable = 1'b1;

    cyc = 0; msgIdx = 0; byteIdx = 0; recN = 0; prevHold = 1'b0; prevByte = '0;
    forever begin
      @(negedge clk);
      cyc++;
      case (readyMode)
        0: txReady = 1'b1;
        1: txReady = cyc[0];
        default: txReady = (cyc % 3) != 0;
      endcase
      msgValid = (msgIdx < 2) && (msgIdx > 0 || cyc > delay);
      msgData  = dataOf(n, msgIdx, byteIdx);
      msgLast  = (msgIdx < 2) && (byteIdx == lens[msgIdx < 2 ? msgIdx : 1] - 1);
      #1;
      if (prevHold) begin
        // R10: offered character held while stalled
        check(txValid && txByte == prevByte, "R10 held character", txByte, prevByte);
      end
      prevHold = txValid && !txReady;
      prevByte = txByte;
      if (msgReady) check(txReady, "R5 msgReady without txReady", txReady, 1);
      if (txValid && txReady && recN < 1024) begin
        rec[recN] = txByte;
        recData[recN] = msgValid && msgReady;
        recN++;
      end
      if (msgValid && msgReady) begin
        if (msgLast) begin
          msgIdx++;
          byteIdx = 0;
          pairCount = 4'(n2); // changed while check bytes still pending
        end else begin
          byteIdx++;
        end
      end
      if (msgIdx == 2) enable = 1'b0;
      if (!enable && !rts) break;
      if (cyc > 4000) begin
        fails++;
        $display("FAIL watchdog: case %0d stuck (actual %0d cycles, expected < 4000)", n, cyc);
        break;
      end
    end

    s1w = wire8(syn1Code, msb);
    s2w = wire8(syn2Code, msb);

    k = -1;
    for (int i = 0; i < recN; i++) begin
      if (recData[i] && k < 0) k = i;
    end
    check(k >= 0, "R5 no data character seen", k, 0);
    if (k < 0) return;

    // R4: whole pairs, SYN1 then SYN2, before the first data character
    check(k % 2 == 0, "R4 even sync count", k, k + (k % 2));
    for (int j = 0; j < k; j++) begin
      check(rec[j] == ((j % 2 == 0) ? s1w : s2w), "R4 sync order", rec[j],
            (j % 2 == 0) ? s1w : s2w);
    end
    // R2: leading pair count
    if (delay == 0) check(k == 2 * (n1 + 1), "R2 leading pairs exact", k, 2 * (n1 + 1));
    else            check(k >= 2 * (n1 + 1), "R2 leading pairs minimum", k, 2 * (n1 + 1));

    dtag = msb ? "R8 data" : (par ? "R6 data parity" : "R5 data");
    ctag = msb ? "R8 check" : "R7 check";
    expN = 0;
    for (int m = 0; m < 2; m++) begin
      for (int i = 0; i < lens[m]; i++) begin
        c = dataOf(n, m, i);
        if (par) c = {^c[6:0], c[6:0]};
        pushExp(wire8(c, msb), dtag);
      end
      pushExp(wire8(chkValue[7:0], msb), ctag);
      if (!par) pushExp(wire8(chkValue[15:8], msb), ctag);
      if (m == 0) begin
        for (int p = 0; p <= n2; p++) begin
          pushExp(s1w, "R3 gap SYN1");
          pushExp(s2w, "R3 gap SYN2");
        end
      end
    end
    for (int i = 0; i < expN; i++) begin
      if (k + i < recN) check(rec[k+i] == expB[i], expTag[i], rec[k+i], expB[i]);
      else              check(1'b0, expTag[i], -1, expB[i]);
    end

    // R9: stops on a completed pair after enable drops
    t = recN - (k + expN);
    check(t >= 2 && t % 2 == 0, "R9 trailing pairs", t, 2);
    for (int j = 0; j < t; j++) begin
      check(rec[k+expN+j] == ((j % 2 == 0) ? s1w : s2w), "R9 trailing sync",
            rec[k+expN+j], (j % 2 == 0) ? s1w : s2w);
    end
    check(!txValid, "R9 txValid after stop", txValid, 0);
  endtask

  initial begin
    for (int n = 0; n < 16; n++) begin
      for (int m = 0; m < 4; m++) begin
        runCase(n, n, (n * 7 + m) % 16, m[0], m[1], ((n + m) % 2) == 1,
                (m == 3) ? 5 + n : 0, (n + m) % 3, 1 + (n + m) % 4, 2 + n % 3);
      end
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule